// File: doc/BRIEF.md
# Priority Interrupt Controller with Shared Sources

This block gathers seven maskable request sources and drives a single interrupt request to a CPU core. Five sources are external pins; the other two are shared request lines, one from a three-channel timer unit and one from a serial channel. Each shared line comes with sub-request flags. When the CPU acknowledges, the vector type it is given names the timer channel or the serial event (receive or transmit) that raised the request.

Each source has a mask bit and a 3-bit priority. A smaller priority number is more urgent. An in-service register records which interrupts the CPU is handling, and a source can interrupt only if its priority is strictly more urgent than every interrupt in service. Software writes an end-of-interrupt command with a source index to close service. A global disable input from the CPU silences the request output. The non-maskable interrupt does not pass through this block.

Source indices are fixed: 0 timer, 1 serial, 2 to 6 for external pins 0 to 4. Writes use `wr_en`/`wr_addr`/`wr_data`. Reads are combinational on `rd_addr`/`rd_data`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all seven mask bits are 1 (read at address 0 as 0x7F), every priority is 7, every external pin is in level mode, the in-service register (address 11) reads 0, and `cpu_irq` is 0.
- R2: Among the sources that are pending, unmasked, not in service and eligible, the one with the smallest 3-bit priority value (written at address 2 + source index) drives `cpu_irq` high, and `irq_vec` shows its vector.
- R3: The mask register is at address 0, with bit i masking source i. A source whose mask bit is 1 never raises `cpu_irq`.
- R4: While `cpu_irq_dis` is 1, `cpu_irq` is 0 regardless of masks and pending requests.
- R5: The timer vector depends on the lowest-numbered set channel flag: channel 0 gives 8, channel 1 gives 18, channel 2 gives 19. With no flag set it is 8.
- R6: The serial vector is 20 when the receive flag is set, and 21 when only the transmit flag is set.
- R7: A `cpu_ack` pulse while `cpu_irq` is 1 sets the in-service bit of the winning source and clears its edge latch. A pulse while `cpu_irq` is 0 changes nothing.
- R8: While any in-service bit is set, only sources whose priority value is strictly less than the smallest priority value in service can raise `cpu_irq`. This allows nesting and blocks sources of equal or lower urgency.
- R9: A write of source index k (0 to 6) to address 9 clears in-service bit k. An index of 7 is ignored.
- R10: The mode register is at address 1, with bit j = 1 making external pin j edge-triggered. In edge mode a rising edge is latched as pending until it is acknowledged. In level mode the pending bit follows the pin. The raw pending bits can be read at address 10, with bit i for source i.
- R11: When priorities are equal, the lower source index wins, giving the order timer, serial, then pins 0 to 4.
- R12: External pins 0 to 4 give vectors 12, 13, 14, 15 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 5 | External request pins 0..4 |
| tmr_req | input | 1 | Shared timer-unit request |
| tmr_chan | input | 3 | Timer channel sub-request flags |
| ser_req | input | 1 | Shared serial-channel request |
| ser_rx | input | 1 | Serial receive sub-request flag |
| ser_tx | input | 1 | Serial transmit sub-request flag |
| cpu_irq_dis | input | 1 | Global disable from the CPU |
| cpu_ack | input | 1 | Interrupt acknowledge pulse |
| cpu_irq | output | 1 | Prioritized request to the CPU |
| irq_vec | output | 8 | Vector type of the current winner |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
A wrong in-service bit appears at the ports one clock after the acknowledge edge. Either a blocked source of equal priority raises `cpu_irq`, or a nesting source stays silent. A stale edge latch keeps the pending bit set after acknowledge. Both are visible on the next read at address 10 or 11. Arbitration and vector errors appear combinationally on `cpu_irq` and `irq_vec` in the same cycle the inputs change, so every check samples half a cycle after the driving edge.

// File: rtl/irq_pkg.sv
// Package: shared constants for the priority interrupt controller.
// Assumes source index order timer, serial, external pins 0..N-1.
package irq_pkg;

    localparam int SRC_TMR  = 0;
    localparam int SRC_SER  = 1;
    localparam int SRC_EXT0 = 2;

    localparam logic [7:0] VEC_TMR0   = 8'd8;
    localparam logic [7:0] VEC_TMR1   = 8'd18;
    localparam logic [7:0] VEC_TMR2   = 8'd19;
    localparam logic [7:0] VEC_SER_RX = 8'd20;
    localparam logic [7:0] VEC_SER_TX = 8'd21;

    localparam logic [3:0] A_MASK = 4'd0;
    localparam logic [3:0] A_MODE = 4'd1;
    localparam logic [3:0] A_PRI0 = 4'd2;
    localparam logic [3:0] A_EOI  = 4'd9;
    localparam logic [3:0] A_PEND = 4'd10;
    localparam logic [3:0] A_ISR  = 4'd11;

    // Vector for external pin j: 12..15 for pins 0..3, then 17 upward.
    function automatic logic [7:0] ext_vec(input int j);
        if (j < 4) return 8'(12 + j);
        return 8'(17 + (j - 4));
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
// Module: per-pin request conditioning for one external interrupt pin.
// In edge mode a rising edge sets a latch held until clr; in level mode
// the request follows the pin. Assumes pin is already synchronous to clk.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic pin_d;
    logic lat_q;

    // Track previous pin value and the rising-edge latch; a new edge wins over clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_d <= 1'b0;
            lat_q <= 1'b0;
        end else begin
            pin_d <= pin;
            if (!edge_mode)
                lat_q <= 1'b0;
            else if (pin && !pin_d)
                lat_q <= 1'b1;
            else if (clr)
                lat_q <= 1'b0;
        end
    end

    // Select the request source by mode.
    always_comb req = edge_mode ? lat_q : pin;

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pin && !pin_d) |=> (req || !edge_mode)); // R10

endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational priority pick among eligible sources.
// Smaller priority value wins; equal values resolve to the lower index.
module irq_arbiter #(
    parameter int NSRC = 7,
    parameter int PW   = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         elig,
    input  logic [NSRC-1:0][PW-1:0] prio,
    output logic                    win_vld,
    output logic [IW-1:0]           win_idx
);
    logic [PW-1:0] best_p;

    // Scan from the highest index down so ties settle on the lowest index.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        best_p  = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_vld || prio[i] <= best_p)) begin
                win_vld = 1'b1;
                win_idx = IW'(i);
                best_p  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_vec_sel.sv
// Module: maps the winning source and sub-request flags to a vector type.
// Assumes source order from irq_pkg.
module irq_vec_sel #(
    parameter int NSRC = 7,
    parameter int NTMR = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [IW-1:0]   win_idx,
    input  logic [NTMR-1:0] tmr_chan,
    input  logic            ser_rx,
    input  logic            ser_tx,
    output logic [7:0]      vec
);
    import irq_pkg::*;

    logic [7:0] tmr_vec;
    logic [7:0] ext_tab [NSRC];

    // Timer channel decode: lowest set flag, channel 0 when none set.
    always_comb begin
        tmr_vec = VEC_TMR0;
        for (int c = NTMR - 1; c >= 0; c--) begin
            if (tmr_chan[c])
                tmr_vec = (c == 0) ? VEC_TMR0 : (c == 1) ? VEC_TMR1 : VEC_TMR2;
        end
    end

    // Build the per-index external vector table.
    for (genvar g = 0; g < NSRC; g++) begin : g_ext
        if (g >= SRC_EXT0) begin : g_pin
            assign ext_tab[g] = ext_vec(g - SRC_EXT0);
        end else begin : g_none
            assign ext_tab[g] = 8'd0;
        end
    end

    // Final vector mux on the winner index.
    always_comb begin
        if (int'(win_idx) == SRC_TMR)
            vec = tmr_vec;
        else if (int'(win_idx) == SRC_SER)
            vec = (ser_tx && !ser_rx) ? VEC_SER_TX : VEC_SER_RX;
        else
            vec = ext_tab[win_idx];
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority interrupt controller with shared sources.
// Holds mask, mode, priority and in-service state; gates eligibility by
// the in-service threshold and drives request and vector to the CPU.
// Assumes all inputs synchronous to clk and cpu_ack a one-cycle pulse.
module prio_irq_ctrl #(
    parameter int NEXT = 5,
    parameter int NTMR = 3,
    parameter int PW   = 3,
    parameter int AW   = 4,
    parameter int DW   = 8,
    localparam int NSRC = NEXT + 2,
    localparam int IW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_irq,
    input  logic            tmr_req,
    input  logic [NTMR-1:0] tmr_chan,
    input  logic            ser_req,
    input  logic            ser_rx,
    input  logic            ser_tx,
    input  logic            cpu_irq_dis,
    input  logic            cpu_ack,
    output logic            cpu_irq,
    output logic [7:0]      irq_vec,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data
);
    import irq_pkg::*;

    logic [NSRC-1:0]         mask_q;
    logic [NEXT-1:0]         mode_q;
    logic [NSRC-1:0][PW-1:0] prio_q;
    logic [NSRC-1:0]         isr_q;
    logic [NSRC-1:0]         pend;
    logic [NSRC-1:0]         elig;
    logic [PW:0]             thresh;
    logic                    win_vld;
    logic [IW-1:0]           win_idx;
    logic                    ack_take;
    logic                    eoi_wr;

    assign ack_take = cpu_ack && cpu_irq;
    assign eoi_wr   = wr_en && (wr_addr == AW'(A_EOI)) && (wr_data < DW'(NSRC));

    // Configuration registers: mask, edge mode and per-source priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= '0;
            prio_q <= '1;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_MASK)) mask_q <= wr_data[NSRC-1:0];
            if (wr_addr == AW'(A_MODE)) mode_q <= wr_data[NEXT-1:0];
            for (int i = 0; i < NSRC; i++)
                if (wr_addr == AW'(int'(A_PRI0) + i)) prio_q[i] <= wr_data[PW-1:0];
        end
    end

    // In-service register: set on accepted acknowledge, cleared by EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (ack_take && win_idx == IW'(i))
                    isr_q[i] <= 1'b1;
                else if (eoi_wr && wr_data[IW-1:0] == IW'(i))
                    isr_q[i] <= 1'b0;
            end
        end
    end

    // Shared sources are level requests straight from their units.
    assign pend[SRC_TMR] = tmr_req;
    assign pend[SRC_SER] = ser_req;

    // One conditioning latch per external pin.
    for (genvar j = 0; j < NEXT; j++) begin : g_pin
        irq_edge_latch u_lat (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (ext_irq[j]),
            .edge_mode (mode_q[j]),
            .clr       (ack_take && win_idx == IW'(SRC_EXT0 + j)),
            .req       (pend[SRC_EXT0 + j])
        );
    end

    // Threshold: smallest priority in service, or one past the range if idle.
    always_comb begin
        thresh = {1'b1, {PW{1'b0}}};
        for (int i = 0; i < NSRC; i++)
            if (isr_q[i] && {1'b0, prio_q[i]} < thresh) thresh = {1'b0, prio_q[i]};
    end

    // Eligibility: pending, unmasked, not in service, strictly above threshold.
    always_comb begin
        for (int i = 0; i < NSRC; i++)
            elig[i] = pend[i] && !mask_q[i] && !isr_q[i] && ({1'b0, prio_q[i]} < thresh);
    end

    irq_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .elig    (elig),
        .prio    (prio_q),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    irq_vec_sel #(.NSRC(NSRC), .NTMR(NTMR)) u_vec (
        .win_idx  (win_idx),
        .tmr_chan (tmr_chan),
        .ser_rx   (ser_rx),
        .ser_tx   (ser_tx),
        .vec      (irq_vec)
    );

    // Request to the CPU, gated by the global disable.
    assign cpu_irq = win_vld && !cpu_irq_dis;

    // Combinational register read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_MASK)) rd_data = DW'(mask_q);
        else if (rd_addr == AW'(A_MODE)) rd_data = DW'(mode_q);
        else if (rd_addr == AW'(A_PEND)) rd_data = DW'(pend);
        else if (rd_addr == AW'(A_ISR)) rd_data = DW'(isr_q);
        else
            for (int i = 0; i < NSRC; i++)
                if (rd_addr == AW'(int'(A_PRI0) + i)) rd_data = DW'(prio_q[i]);
    end

    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> !mask_q[win_idx]); // R3
    AST_WIN_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ({1'b0, prio_q[win_idx]} < thresh)); // R8
    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> isr_q[$past(win_idx)]); // R7
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !(ack_take && win_idx == wr_data[IW-1:0])) |=> !isr_q[$past(wr_data[IW-1:0])]); // R9
    AST_TMR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && int'(win_idx) == SRC_TMR) |->
        (irq_vec == VEC_TMR0 || irq_vec == VEC_TMR1 || irq_vec == VEC_TMR2)); // R5

endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] ext_irq;
    logic       tmr_req;
    logic [2:0] tmr_chan;
    logic       ser_req, ser_rx, ser_tx;
    logic       cpu_irq_dis, cpu_ack;
    logic       cpu_irq;
    logic [7:0] irq_vec;
    logic       wr_en;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_req(tmr_req),
        .tmr_chan(tmr_chan), .ser_req(ser_req), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .cpu_irq_dis(cpu_irq_dis), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
        .irq_vec(irq_vec), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_irq = '0; tmr_req = 0; tmr_chan = '0;
        ser_req = 0; ser_rx = 0; ser_tx = 0; cpu_irq_dis = 0; cpu_ack = 0;
        wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        rd_addr = a; #1;
        v = int'(rd_data);
    endtask

    task automatic look(output int irq, output int vec);
        @(negedge clk); #1;
        irq = int'(cpu_irq); vec = int'(irq_vec);
    endtask

    task automatic ack(output int vec);
        @(negedge clk);
        cpu_ack = 1'b1; #1;
        vec = int'(irq_vec);
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic t_reset();
        int v, i, q;
        do_reset();
        look(i, q); chk("R1 irq", i, 0);
        rd(4'd0, v);  chk("R1 mask", v, 8'h7F);
        rd(4'd2, v);  chk("R1 prio", v, 7);
        rd(4'd1, v);  chk("R1 mode", v, 0);
        rd(4'd11, v); chk("R1 isr", v, 0);
    endtask

    task automatic t_mask_dis();
        int i, q;
        do_reset();
        @(negedge clk) ext_irq[0] = 1'b1;
        look(i, q); chk("R3 masked", i, 0);
        wr(4'd0, 8'h7B);
        look(i, q); chk("R12 int0 irq", i, 1); chk("R12 int0 vec", q, 12);
        @(negedge clk) cpu_irq_dis = 1'b1;
        look(i, q); chk("R4 disable", i, 0);
        @(negedge clk) cpu_irq_dis = 1'b0;
        wr(4'd0, 8'h7F);
        look(i, q); chk("R3 remask", i, 0);
    endtask

    task automatic t_prio();
        int i, q;
        do_reset();
        wr(4'd0, 8'h03);
        wr(4'd5, 8'd2); wr(4'd6, 8'd5); wr(4'd7, 8'd2);
        @(negedge clk) ext_irq = 5'b01110;
        look(i, q); chk("R2 irq", i, 1); chk("R11 tie vec", q, 13);
        wr(4'd7, 8'd1);
        look(i, q); chk("R2 better", q, 15);
        @(negedge clk) ext_irq = 5'b10000;
        look(i, q); chk("R12 int4 vec", q, 17);
    endtask

    task automatic t_nest();
        int v, i, q;
        do_reset();
        look(i, q);
        ack(q);
        rd(4'd11, v); chk("R7 ack ignored", v, 0);
        wr(4'd4, 8'd3); wr(4'd5, 8'd3); wr(4'd6, 8'd1);
        wr(4'd0, 8'h63);
        @(negedge clk) ext_irq = 5'b00011;
        look(i, q); chk("R11 tie", q, 12);
        ack(q); chk("R7 ack vec", q, 12);
        rd(4'd11, v); chk("R7 isr set", v, 8'h04);
        look(i, q); chk("R8 equal blocked", i, 0);
        @(negedge clk) ext_irq[2] = 1'b1;
        look(i, q); chk("R8 nest irq", i, 1); chk("R8 nest vec", q, 14);
        ack(q);
        rd(4'd11, v); chk("R8 isr nested", v, 8'h14);
        look(i, q); chk("R8 all blocked", i, 0);
        wr(4'd9, 8'd7);
        rd(4'd11, v); chk("R9 index 7 ignored", v, 8'h14);
        wr(4'd9, 8'd4);
        rd(4'd11, v); chk("R9 eoi", v, 8'h04);
        look(i, q); chk("R9 reopen", q, 14);
    endtask

    task automatic t_shared();
        int i, q;
        do_reset();
        wr(4'd0, 8'h7C);
        wr(4'd2, 8'd0); wr(4'd3, 8'd1);
        @(negedge clk) begin tmr_req = 1; tmr_chan = 3'b110; end
        look(i, q); chk("R5 ch1", q, 18);
        @(negedge clk) tmr_chan = 3'b100;
        look(i, q); chk("R5 ch2", q, 19);
        @(negedge clk) tmr_chan = 3'b001;
        look(i, q); chk("R5 ch0", q, 8);
        @(negedge clk) begin tmr_req = 0; tmr_chan = 0; ser_req = 1; ser_rx = 1; ser_tx = 1; end
        look(i, q); chk("R6 rx", q, 20);
        @(negedge clk) ser_rx = 0;
        look(i, q); chk("R6 tx", q, 21);
    endtask

    task automatic t_edge();
        int v, i, q;
        do_reset();
        wr(4'd1, 8'h10); wr(4'd0, 8'h1F); wr(4'd8, 8'd2);
        look(i, q); chk("R10 idle", i, 0);
        @(negedge clk) ext_irq[4] = 1'b1;
        look(i, q); chk("R10 edge irq", i, 1); chk("R10 edge vec", q, 17);
        rd(4'd10, v); chk("R10 pend", v, 8'h40);
        ack(q);
        rd(4'd10, v); chk("R7 latch cleared", v, 0);
        wr(4'd9, 8'd6);
        look(i, q); chk("R10 held pin no edge", i, 0);
        @(negedge clk) ext_irq[4] = 1'b0;
        @(negedge clk) ext_irq[4] = 1'b1;
        look(i, q); chk("R10 re-edge", i, 1);
        @(negedge clk) ext_irq[3] = 1'b1;
        rd(4'd10, v); chk("R10 level follows", v, 8'h60);
        @(negedge clk) ext_irq[3] = 1'b0;
        rd(4'd10, v); chk("R10 level drops", v, 8'h40);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mask_dis();
        t_prio();
        t_nest();
        t_shared();
        t_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule